// File: doc/BRIEF.md
# Byte-Lane Register Bank with Write Side-Effects

This block is a small bank of control registers that answers a simple internal request bus. Each cycle the requester presents an address, write data, a read strobe or a write strobe, and one enable bit per byte lane. In the same cycle the bank returns read data, a ready flag and an error flag.

The address decoder selects one register by exact match against its word-aligned base. Every byte lane of every register is a field. Each field has its own write behaviour, fixed at elaboration: plain store, set-on-one, clear-on-one, toggle-on-one, set-on-zero or toggle-on-zero. A field changes only when its lane enable is high. Lanes can also be made read-only. For each field the bank drives an access strobe and a modify strobe, which surrounding logic can use to react to software activity. Addresses that match no register are answered at once with an error and zero data.

With the default parameters the bank has four 32-bit registers at byte addresses 0x00, 0x04, 0x08 and 0x0C. Lane `l` occupies bits `8l+7:8l`. Reset is synchronous and active high.

Top module: `regbank_top`

## Requirements
- R1: A register is selected only when `bus_addr` equals its base address (register `i` at `4*i`, for i = 0..3). Every other address, including unaligned ones and addresses at or above 0x10, selects nothing.
- R2: In a plain-write field (all lanes of register 0, lane 1 of register 2, lanes 0 and 1 of register 3), a write with lane `l` enabled stores `bus_wdata[8l+7:8l]`. Disabled lanes keep their value.
- R3: A field does not change on an idle cycle, a read, a miss, a write to another register, or a write with its lane enable low.
- R4: Register 1 lanes: lane 0 becomes old OR data, lane 1 becomes old AND NOT data, lane 2 becomes old XOR data. Register 2 lane 2 is OR (set) and lane 3 is AND NOT (clear).
- R5: Register 1 lane 3 becomes old AND data (set on zero). Register 2 lane 0 becomes old XNOR data (toggle on zero).
- R6: `bus_ready` equals `bus_rvalid | bus_wvalid` in the same cycle. On a selected register, `bus_rdata` is the full 32-bit contents, whatever the byte enables are.
- R7: On a miss with a valid request, `bus_rdata` is 0 and `bus_err` is 1. Stored registers are left unchanged.
- R8: On a selected register, `bus_err` is 1 when no enabled lane is implemented for that direction. All lanes are readable. Lanes 2 and 3 of register 3 are read-only: writes to them are ignored, and they always read their reset value.
- R9: `sw_acc[4*r+l]` is high when register `r` is selected, a read or write is valid, and `bus_be[l]` is set. Otherwise it is low.
- R10: `sw_mod[4*r+l]` is high when register `r` is selected with a valid write, `bus_be[l]` is set and lane `l` is writable. Otherwise it is low.
- R11: While `rst` is high at a clock edge, every register loads its reset value: reg0 0x00000000, reg1 0x5A3CF00F, reg2 0xFF00A5C3, reg3 0xBEEF0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_wvalid | input | 1 | Write request valid |
| bus_rvalid | input | 1 | Read request valid |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Request completed this cycle |
| bus_err | output | 1 | Request failed |
| sw_acc | output | 16 | Per-field software access strobe |
| sw_mod | output | 16 | Per-field software modify strobe |

## Verification
The bench goes after the lane-level corners. A partial byte-enable write must touch only its lanes, and a wrong lane slice would corrupt the neighbouring bytes. Each side-effect mode is fed all-ones and all-zeros data; a swapped operator (OR for AND-NOT, XOR for XNOR) would give the complement or leave the field unchanged. Unaligned and out-of-range addresses must return zero with an error; a decoder that ignores the low bits would alias them onto real registers. Writes that enable only read-only lanes, and reads with no lane enabled, must flag an error without changing state; a design that wrote the read-only lanes would lose the constants in register 3. A behavioural model also checks every output on each cycle of a long mixed stimulus, so strobe bits raised for the wrong register or lane are caught as soon as they occur.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int LANE_W = 8;

  // Write behaviour of one byte-lane field
  typedef enum logic [2:0] {
    WM_PLAIN = 3'd0,
    WM_SET   = 3'd1,
    WM_CLR   = 3'd2,
    WM_TOG   = 3'd3,
    WM_ZSET  = 3'd4,
    WM_ZTOG  = 3'd5
  } wr_mode_e;

  function automatic logic [LANE_W-1:0] wr_apply(
    input wr_mode_e          mode,
    input logic [LANE_W-1:0] cur,
    input logic [LANE_W-1:0] wd
  );
    case (mode)
      WM_SET:  return cur | wd;
      WM_CLR:  return cur & ~wd;
      WM_TOG:  return cur ^ wd;
      WM_ZSET: return cur & wd;
      WM_ZTOG: return cur ~^ wd;
      default: return wd;
    endcase
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int STRIDE   = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rvalid,
  input  logic                wvalid,
  output logic [NUM_REGS-1:0] hit,
  output logic [NUM_REGS-1:0] rd_stb,
  output logic [NUM_REGS-1:0] wr_stb
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * STRIDE);
    assign hit[i]    = (addr == BASE);
    assign rd_stb[i] = hit[i] & rvalid;
    assign wr_stb[i] = hit[i] & wvalid;
  end

endmodule

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter wr_mode_e          MODE = WM_PLAIN,
  parameter logic [LANE_W-1:0] RST  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= wr_apply(MODE, q, wd);
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> q == $past(q)); // R3

  if (MODE == WM_SET) begin : g_set_chk
    AST_SET_ONLY_RISES: assert property (@(posedge clk) disable iff (rst)
      we |=> (q & $past(q)) == $past(q)); // R4
  end

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int LANES    = DATA_W / 8,
  parameter logic [NUM_REGS*LANES-1:0] RD_LANES = '1,
  parameter logic [NUM_REGS*LANES-1:0] WR_LANES = '1
) (
  input  logic [NUM_REGS-1:0]        hit,
  input  logic [NUM_REGS*DATA_W-1:0] reg_flat,
  input  logic                       rvalid,
  input  logic                       wvalid,
  input  logic [LANES-1:0]           be,
  output logic [DATA_W-1:0]          rdata,
  output logic                       ready,
  output logic                       err
);

  logic any_hit;
  logic rd_ok;
  logic wr_ok;

  always_comb begin
    rdata   = '0;
    any_hit = 1'b0;
    rd_ok   = 1'b0;
    wr_ok   = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        rdata   = reg_flat[i*DATA_W +: DATA_W];
        rd_ok   = |(be & RD_LANES[i*LANES +: LANES]);
        wr_ok   = |(be & WR_LANES[i*LANES +: LANES]);
      end
    end
    ready = rvalid | wvalid;
    err   = ready & ~(any_hit & ((rvalid & rd_ok) | (wvalid & wr_ok)));
  end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*(DATA_W/8)*3-1:0] FIELD_MODE = {
    3'd0, 3'd0, 3'd0, 3'd0,
    3'd2, 3'd1, 3'd0, 3'd5,
    3'd4, 3'd3, 3'd2, 3'd1,
    3'd0, 3'd0, 3'd0, 3'd0},
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = {
    32'hBEEF_0000, 32'hFF00_A5C3, 32'h5A3C_F00F, 32'h0000_0000},
  parameter logic [NUM_REGS*(DATA_W/8)-1:0] RD_LANES = 16'hFFFF,
  parameter logic [NUM_REGS*(DATA_W/8)-1:0] WR_LANES = 16'h3FFF
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic                            bus_wvalid,
  input  logic                            bus_rvalid,
  input  logic [DATA_W/8-1:0]             bus_be,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic                            bus_ready,
  output logic                            bus_err,
  output logic [NUM_REGS*(DATA_W/8)-1:0]  sw_acc,
  output logic [NUM_REGS*(DATA_W/8)-1:0]  sw_mod
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int STRIDE = LANES;

  logic [NUM_REGS-1:0]        hit;
  logic [NUM_REGS-1:0]        rd_stb;
  logic [NUM_REGS-1:0]        wr_stb;
  logic [NUM_REGS*DATA_W-1:0] reg_flat;

  regbank_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .STRIDE  (STRIDE)
  ) u_decode (
    .addr  (bus_addr),
    .rvalid(bus_rvalid),
    .wvalid(bus_wvalid),
    .hit   (hit),
    .rd_stb(rd_stb),
    .wr_stb(wr_stb)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int K = r * LANES + l;
      localparam logic [LANE_W-1:0] RV = RST_VAL[r*DATA_W + l*LANE_W +: LANE_W];

      assign sw_acc[K] = (rd_stb[r] | wr_stb[r]) & bus_be[l];

      if (WR_LANES[K]) begin : g_rw
        logic we;
        assign we        = wr_stb[r] & bus_be[l];
        assign sw_mod[K] = we;
        regbank_field #(
          .MODE(wr_mode_e'(FIELD_MODE[K*3 +: 3])),
          .RST (RV)
        ) u_field (
          .clk(clk),
          .rst(rst),
          .we (we),
          .wd (bus_wdata[l*LANE_W +: LANE_W]),
          .q  (reg_flat[r*DATA_W + l*LANE_W +: LANE_W])
        );
      end else begin : g_ro
        assign sw_mod[K] = 1'b0;
        assign reg_flat[r*DATA_W + l*LANE_W +: LANE_W] = RV;
      end
    end
  end

  regbank_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .LANES   (LANES),
    .RD_LANES(RD_LANES),
    .WR_LANES(WR_LANES)
  ) u_rdmux (
    .hit     (hit),
    .reg_flat(reg_flat),
    .rvalid  (bus_rvalid),
    .wvalid  (bus_wvalid),
    .be      (bus_be),
    .rdata   (bus_rdata),
    .ready   (bus_ready),
    .err     (bus_err)
  );

  AST_MISS_RESP: assert property (@(posedge clk) disable iff (rst)
    ((bus_rvalid || bus_wvalid) && hit == '0) |-> (bus_err && bus_rdata == '0)); // R7

  AST_MOD_WITHIN_ACC: assert property (@(posedge clk) disable iff (rst)
    $countones(sw_mod & ~sw_acc) == 0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_rvalid || bus_wvalid) |-> (!bus_err && sw_acc == '0)); // R9

endmodule

// File: tb/tb_regbank_top.sv
module tb_regbank_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wvalid;
  logic        bus_rvalid;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        bus_err;
  logic [15:0] sw_acc;
  logic [15:0] sw_mod;

  int checks = 0;
  int errors = 0;

  logic [31:0] mreg [4];

  always #5 clk = ~clk;

  regbank_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wvalid(bus_wvalid), .bus_rvalid(bus_rvalid), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .sw_acc(sw_acc), .sw_mod(sw_mod)
  );

  function automatic logic [31:0] reset_value(int r);
    case (r)
      1: return 32'h5A3C_F00F;
      2: return 32'hFF00_A5C3;
      3: return 32'hBEEF_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit writable(int r, int l);
    return !(r == 3 && l >= 2);
  endfunction

  function automatic logic [7:0] ref_op(int r, int l, logic [7:0] o, logic [7:0] w);
    if (r == 1) begin
      case (l)
        0: return o | w;
        1: return o & ~w;
        2: return o ^ w;
        default: return o & w;
      endcase
    end
    if (r == 2) begin
      case (l)
        0: return ~(o ^ w);
        1: return w;
        2: return o | w;
        default: return o & ~w;
      endcase
    end
    return w;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 4; r++) mreg[r] = reset_value(r);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit rv, bit wv, logic [7:0] a, logic [3:0] be,
                      logic [31:0] wd, string tag);
    int          hr;
    logic [31:0] e_rdata;
    logic        e_err;
    logic [15:0] e_acc;
    logic [15:0] e_mod;
    bit          rd_ok;
    bit          wr_ok;
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = wd;
    bus_rvalid = rv; bus_wvalid = wv;
    #1;
    hr = (a[1:0] == 2'b00 && a < 8'h10) ? int'(a >> 2) : -1;
    e_acc = '0; e_mod = '0;
    if (hr < 0) begin
      e_rdata = '0;
      e_err   = rv | wv;
    end else begin
      e_rdata = mreg[hr];
      rd_ok = (be != 4'b0);
      wr_ok = 1'b0;
      for (int l = 0; l < 4; l++) begin
        if (be[l] && writable(hr, l)) wr_ok = 1'b1;
        if (be[l] && (rv || wv)) e_acc[hr*4+l] = 1'b1;
        if (be[l] && wv && writable(hr, l)) e_mod[hr*4+l] = 1'b1;
      end
      e_err = (rv || wv) && !((rv && rd_ok) || (wv && wr_ok));
    end
    chk(tag, "rdata", bus_rdata, e_rdata);
    chk(tag, "err", 32'(bus_err), 32'(e_err));
    chk(tag, "ready", 32'(bus_ready), 32'(rv | wv));
    chk(tag, "sw_acc", 32'(sw_acc), 32'(e_acc));
    chk(tag, "sw_mod", 32'(sw_mod), 32'(e_mod));
    @(posedge clk);
    if (wv && hr >= 0) begin
      for (int l = 0; l < 4; l++)
        if (be[l] && writable(hr, l))
          mreg[hr][l*8 +: 8] = ref_op(hr, l, mreg[hr][l*8 +: 8], wd[l*8 +: 8]);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [3:0] be, string tag);
    step(1'b1, 1'b0, a, be, 32'h0, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d, string tag);
    step(1'b0, 1'b1, a, be, d, tag);
  endtask

  task automatic read_all(string tag);
    for (int r = 0; r < 4; r++) rd(8'(r * 4), 4'hF, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_addr = '0; bus_wdata = '0; bus_be = '0;
    bus_rvalid = 1'b0; bus_wvalid = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11: reset contents
    read_all("R11");
    // R1: each base selects its own register; neighbours do not alias
    rd(8'h04, 4'hF, "R1");
    rd(8'h05, 4'hF, "R1");
    rd(8'h0C, 4'hF, "R1");
    // R2: partial plain write
    wr(8'h00, 4'b0101, 32'h1122_3344, "R2");
    rd(8'h00, 4'hF, "R2");
    // R6: read ignores byte enables for data
    rd(8'h00, 4'b0001, "R6");
    // R4: set / clear / toggle lanes with all-ones data
    wr(8'h04, 4'hF, 32'hFFFF_FFFF, "R4");
    rd(8'h04, 4'hF, "R4");
    // R5: zero-set and zero-toggle
    wr(8'h08, 4'hF, 32'h0F0F_0F0F, "R5");
    rd(8'h08, 4'hF, "R5");
    wr(8'h04, 4'b1000, 32'h0000_0000, "R5");
    rd(8'h04, 4'hF, "R5");
    // R3: no-enable write, idle, write to other register
    wr(8'h00, 4'b0000, 32'hFFFF_FFFF, "R3");
    step(1'b0, 1'b0, 8'h00, 4'hF, 32'hFFFF_FFFF, "R3");
    wr(8'h0C, 4'b0011, 32'h0000_1234, "R3");
    read_all("R3");
    // R8: read-only lanes and empty read
    wr(8'h0C, 4'b1100, 32'h1234_5678, "R8");
    rd(8'h0C, 4'hF, "R8");
    wr(8'h0C, 4'hF, 32'hAAAA_5555, "R8");
    rd(8'h0C, 4'hF, "R8");
    rd(8'h08, 4'b0000, "R8");
    // R7: misses
    rd(8'h10, 4'hF, "R7");
    rd(8'h02, 4'hF, "R7");
    wr(8'h14, 4'hF, 32'hDEAD_BEEF, "R7");
    wr(8'hFF, 4'hF, 32'hDEAD_BEEF, "R7");
    read_all("R7");
    // R9 / R10: strobe lanes
    wr(8'h08, 4'b0110, 32'h00FF_FF00, "R10");
    rd(8'h04, 4'b1001, "R9");
    wr(8'h0C, 4'b1110, 32'h0, "R10");

    // Mixed stimulus compared against the model every cycle
    for (int n = 0; n < 600; n++) begin
      int          op;
      int          sel;
      logic [7:0]  a;
      op  = $urandom_range(0, 2);
      sel = $urandom_range(0, 7);
      case (sel)
        0, 1, 2, 3: a = 8'(sel * 4);
        4: a = 8'h02;
        5: a = 8'h10;
        6: a = 8'hFC;
        default: a = 8'($urandom);
      endcase
      step(op == 1, op == 2, a, 4'($urandom), $urandom, "R6");
    end

    // R11: synchronous reset in mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    model_reset();
    read_all("R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule